// File: doc/BRIEF.md
# Byte-Addressed Interrupt Priority Store

This block keeps one 8-bit priority for each interrupt source. It has 64 sources by default. A lower value means a more urgent interrupt. The store sits behind a plain register port, which carries a byte offset, a request, a write enable, write data, an access width and read data. The byte offset is the interrupt number, so an access does not have to be word aligned. An access of 2 or 4 bytes reaches the next consecutive interrupts through the higher byte lanes of the data word.

An access width other than 1, 2 or 4 bytes is rejected and raises an error flag. One cycle after every accepted write, the block raises a strobe. Downstream logic uses that strobe to recompute the highest pending interrupt and the running priority. All priorities are exported as one flat vector so that the selection logic can read them in parallel.

Top module: `prio_bank`

## Requirements
- R1: Asserting the active-low asynchronous reset `rst_ni` sets every priority to zero, and the value shows on `prio_o` and on reads.
- R2: A 1-byte access (`size_i` = 1) at offset n writes only priority n from `wdata_i[7:0]`. A read returns priority n in `rdata_o[7:0]`, and bits 31:8 read zero.
- R3: A 2-byte access (`size_i` = 2) at offset n covers priority n in bits 7:0 and priority n+1 in bits 15:8. Bits 31:16 read zero and are not written.
- R4: A 4-byte access (`size_i` = 4) at offset n covers priorities n to n+3, with byte lane k (bits 8k+7:8k) holding priority n+k.
- R5: The interrupt number is the byte offset itself, with no alignment. For example, a 4-byte access at offset 5 covers priorities 5 to 8.
- R6: A request with a `size_i` value other than 1, 2 or 4 drives `err_o` high in the same cycle. It writes nothing, and `rdata_o` reads zero. `err_o` is low when `req_i` is low or the size is legal.
- R7: `reeval_o` is high for exactly the one cycle that follows each request with `we_i` high and a legal size. It is low in every other cycle.
- R8: A byte lane whose interrupt number (offset plus lane) is 64 or more reads zero and ignores writes. The other lanes of the same access behave normally.
- R9: `prio_o[8i+7:8i]` always carries the priority of interrupt i.
- R10: A request with `we_i` low, or a cycle with `req_i` low, leaves every priority unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request this cycle |
| we_i | input | 1 | Write when high, read when low |
| size_i | input | 3 | Access width in bytes (1, 2, 4 legal) |
| addr_i | input | 8 | Byte offset in the priority window (interrupt number) |
| wdata_i | input | 32 | Write data, byte lane k for interrupt offset+k |
| rdata_o | output | 32 | Read data, combinational from offset and width |
| err_o | output | 1 | Illegal access width on the current request |
| reeval_o | output | 1 | One-cycle strobe after an accepted write |
| prio_o | output | 512 | All priorities, 8 bits per interrupt |

## Verification
The bench aims at the following faults:
- **Word-indexed addressing.** Unaligned 2- and 4-byte accesses would hit the wrong interrupts if the design multiplied the offset by four.
- **Too many lanes written.** A narrow write with all-ones filler data would corrupt neighbouring priorities if the design wrote every lane regardless of width.
- **Out-of-range lanes.** An access that straddles the top of the window would wrap onto low interrupts, or return stale data, if the range check were missing.
- **Illegal widths.** These must raise the error and leave the store untouched.
- **Strobe timing.** The strobe is checked in the cycle after each write and after each read, so a strobe that is late, stuck high or raised on reads would be caught.

// File: rtl/prio_pkg.sv
package prio_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned SIZE_W = 3;

  function automatic logic size_ok(input logic [SIZE_W-1:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction
endpackage

// File: rtl/prio_lane_decode.sv
module prio_lane_decode
  import prio_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned LANES   = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              legal_o,
  output logic [LANES-1:0]  lane_hit_o,
  output logic [IDX_W-1:0]  lane_idx_o [LANES]
);
  assign legal_o = size_ok(size_i);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [ADDR_W:0] sum;
    logic            covered;
    logic            in_range;
    assign sum      = {1'b0, addr_i} + (ADDR_W+1)'(k);
    assign covered  = (SIZE_W+1)'(k) < {1'b0, size_i};
    assign in_range = sum < (ADDR_W+1)'(NUM_SRC);
    assign lane_hit_o[k] = legal_o & covered & in_range;
    assign lane_idx_o[k] = sum[IDX_W-1:0];
  end
endmodule

// File: rtl/prio_store.sv
module prio_store
  import prio_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned LANES   = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [LANES-1:0]          wr_lane_i,
  input  logic [IDX_W-1:0]          lane_idx_i [LANES],
  input  logic [LANES*LANE_W-1:0]   wdata_i,
  output logic [NUM_SRC*LANE_W-1:0] prio_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_ent
    logic              hit;
    logic [LANE_W-1:0] nxt;
    logic [LANE_W-1:0] q;

    // at most one lane can address a given entry
    always_comb begin
      hit = 1'b0;
      nxt = q;
      for (int k = 0; k < LANES; k++) begin
        if (wr_lane_i[k] && (lane_idx_i[k] == IDX_W'(i))) begin
          hit = 1'b1;
          nxt = wdata_i[k*LANE_W +: LANE_W];
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (hit) q <= nxt;
    end

    assign prio_o[i*LANE_W +: LANE_W] = q;
  end
endmodule

// File: rtl/prio_read_mux.sv
module prio_read_mux
  import prio_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned LANES   = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC*LANE_W-1:0] prio_i,
  input  logic [LANES-1:0]          lane_hit_i,
  input  logic [IDX_W-1:0]          lane_idx_i [LANES],
  output logic [LANES*LANE_W-1:0]   rdata_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_rd
    assign rdata_o[k*LANE_W +: LANE_W] =
      lane_hit_i[k] ? prio_i[lane_idx_i[k]*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/prio_bank.sv
module prio_bank
  import prio_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned LANES  = DATA_W / LANE_W,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [SIZE_W-1:0]         size_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      err_o,
  output logic                      reeval_o,
  output logic [NUM_SRC*LANE_W-1:0] prio_o
);
  logic             legal;
  logic [LANES-1:0] lane_hit;
  logic [LANES-1:0] wr_lane;
  logic [IDX_W-1:0] lane_idx [LANES];
  logic             reeval_q;

  prio_lane_decode #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .LANES(LANES)
  ) i_dec (
    .addr_i    (addr_i),
    .size_i    (size_i),
    .legal_o   (legal),
    .lane_hit_o(lane_hit),
    .lane_idx_o(lane_idx)
  );

  assign wr_lane = lane_hit & {LANES{req_i & we_i}};

  prio_store #(
    .NUM_SRC(NUM_SRC), .LANES(LANES)
  ) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_lane_i (wr_lane),
    .lane_idx_i(lane_idx),
    .wdata_i   (wdata_i),
    .prio_o    (prio_o)
  );

  prio_read_mux #(
    .NUM_SRC(NUM_SRC), .LANES(LANES)
  ) i_rd (
    .prio_i    (prio_o),
    .lane_hit_i(lane_hit),
    .lane_idx_i(lane_idx),
    .rdata_o   (rdata_o)
  );

  assign err_o = req_i & ~legal;

  // strobe fires even if every lane fell outside the window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reeval_q <= 1'b0;
    else         reeval_q <= req_i & we_i & legal;
  end
  assign reeval_o = reeval_q;
endmodule

// File: rtl/prio_bank_chk.sv
module prio_bank_chk #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic [2:0]           size_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [DATA_W-1:0]    rdata_o,
  input logic                 err_o,
  input logic                 reeval_o,
  input logic [NUM_SRC*8-1:0] prio_o
);
  logic ok_sz;
  assign ok_sz = (size_i == 3'd1) || (size_i == 3'd2) || (size_i == 3'd4);

  assert_err_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ok_sz) |-> err_o);
  assert_no_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i || ok_sz) |-> !err_o);
  assert_err_no_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> $stable(prio_o));
  assert_err_rd_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0));
  assert_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && ok_sz) |=> reeval_o);
  assert_no_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && ok_sz) |=> !reeval_o);
  assert_read_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(prio_o));
  assert_half_upper_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == 3'd2) |-> (rdata_o[DATA_W-1:16] == '0));
  assert_byte_upper_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == 3'd1) |-> (rdata_o[DATA_W-1:8] == '0));
  assert_oob_rd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, addr_i} >= (ADDR_W+1)'(NUM_SRC)) |-> (rdata_o == '0));
  assert_oob_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, addr_i} >= (ADDR_W+1)'(NUM_SRC)) |=> $stable(prio_o));
endmodule

bind prio_bank prio_bank_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .size_i  (size_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .err_o   (err_o),
  .reeval_o(reeval_o),
  .prio_o  (prio_o)
);

// File: tb/test_prio_bank.sv
`timescale 1ns/1ps
module test_prio_bank;
  localparam int N = 64;

  typedef struct packed {
    logic        we;
    logic [2:0]  sz;
    logic [7:0]  ad;
    logic [31:0] wd;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t [0:NV-1] VECS = '{
    '{1'b1, 3'd4, 8'd0,   32'h44332211},
    '{1'b0, 3'd1, 8'd2,   32'hFFFFFFFF},
    '{1'b1, 3'd1, 8'd1,   32'hFFFFFFAA},
    '{1'b0, 3'd4, 8'd0,   32'hFFFFFFFF},
    '{1'b1, 3'd2, 8'd5,   32'hFFFFBBCC},
    '{1'b0, 3'd4, 8'd4,   32'h0},
    '{1'b1, 3'd3, 8'd8,   32'h12345678},
    '{1'b0, 3'd4, 8'd8,   32'h0},
    '{1'b1, 3'd4, 8'd62,  32'hDDCCBBAA},
    '{1'b0, 3'd4, 8'd62,  32'h0},
    '{1'b0, 3'd2, 8'd3,   32'h0},
    '{1'b1, 3'd4, 8'd100, 32'hFFFFFFFF},
    '{1'b0, 3'd4, 8'd60,  32'h0},
    '{1'b1, 3'd4, 8'd7,   32'h0D0C0B0A}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  size_i = 3'd1;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        err_o;
  logic        reeval_o;
  logic [N*8-1:0] prio_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] mdl [N];

  always #2.5 clk_i = ~clk_i;

  prio_bank i_prio_bank (
    .clk_i, .rst_ni, .req_i, .we_i, .size_i, .addr_i, .wdata_i,
    .rdata_o, .err_o, .reeval_o, .prio_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit legal(input logic [2:0] s);
    return (s == 3'd1) || (s == 3'd2) || (s == 3'd4);
  endfunction

  function automatic logic [31:0] mdl_read(input logic [2:0] s, input logic [7:0] a);
    logic [31:0] r = '0;
    if (!legal(s)) return r;
    for (int k = 0; k < 4; k++)
      if (k < int'(s) && int'(a) + k < N) r[k*8 +: 8] = mdl[int'(a) + k];
    return r;
  endfunction

  task automatic mdl_write(input logic [2:0] s, input logic [7:0] a, input logic [31:0] d);
    if (!legal(s)) return;
    for (int k = 0; k < 4; k++)
      if (k < int'(s) && int'(a) + k < N) mdl[int'(a) + k] = d[k*8 +: 8];
  endtask

  function automatic string tag(input vec_t v);
    if (!legal(v.sz)) return "R6";
    if (int'(v.ad) + int'(v.sz) > N) return "R8";
    if (v.sz == 3'd1) return "R2";
    if (v.sz == 3'd2) return "R3";
    if (v.ad[1:0] != 2'b00) return "R5";
    return "R4";
  endfunction

  task automatic access(input vec_t v);
    logic [31:0] rd;
    logic        er;
    @(negedge clk_i);
    req_i = 1'b1; we_i = v.we; size_i = v.sz; addr_i = v.ad; wdata_i = v.wd;
    #1;
    rd = rdata_o; er = err_o;
    check(tag(v), rd, mdl_read(v.sz, v.ad));
    check("R6", {31'b0, er}, {31'b0, !legal(v.sz)});
    if (v.we) mdl_write(v.sz, v.ad, v.wd);
    @(posedge clk_i); #1;
    req_i = 1'b0; we_i = 1'b0;
    check("R7", {31'b0, reeval_o}, {31'b0, v.we && legal(v.sz)});
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < N; i++) check(req, {24'b0, prio_o[i*8 +: 8]}, {24'b0, mdl[i]});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) mdl[i] = '0;
    #1;
    check("R1", {31'b0, reeval_o}, 32'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset state through the read port and the flat vector
    check_all("R1");
    for (int w = 0; w < N; w += 4) access('{1'b0, 3'd4, 8'(w), 32'hFFFFFFFF});

    // table walk
    for (int v = 0; v < NV; v++) access(VECS[v]);
    // R9: flat vector mirrors the model
    check_all("R9");

    // R6: every illegal width flags an error and writes nothing
    for (int s = 0; s < 8; s++)
      if (!legal(3'(s))) access('{1'b1, 3'(s), 8'd10, 32'hA5A5A5A5});
    check_all("R6");

    // R10: idle cycles with write data present change nothing
    @(negedge clk_i);
    we_i = 1'b1; size_i = 3'd4; addr_i = 8'd20; wdata_i = 32'hFFFFFFFF;
    @(posedge clk_i); #1;
    check("R7", {31'b0, reeval_o}, 32'd0);
    we_i = 1'b0;
    check_all("R10");

    // R8: a single byte at the last entry, then just past it
    access('{1'b1, 3'd1, 8'd63, 32'h0000007E});
    access('{1'b1, 3'd1, 8'd64, 32'h0000007F});
    access('{1'b0, 3'd2, 8'd63, 32'h0});
    check_all("R8");

    // R1: asynchronous reset mid-run clears everything
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    for (int i = 0; i < N; i++) mdl[i] = '0;
    check_all("R1");
    check("R1", {31'b0, reeval_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    access('{1'b0, 3'd4, 8'd0, 32'h0});

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule